// File: doc/BRIEF.md
# Nibble-Loaded Bank Register Decoder

This block is the register side of a cartridge bank controller on an 8-bit CPU bus with a 16-bit address. It holds three selectable 8 KB program bank numbers, eight 1 KB character bank numbers and a nametable mirroring mode. Each 8-bit bank number is loaded through two 4-bit writes at a pair of adjacent addresses. The even address of the pair carries the low half and the odd address carries the high half.

The block turns an offset within the 32 KB program area (CPU 0x8000–0xFFFF) into a banked program ROM address. It turns a 13-bit pattern-space video address into a banked character ROM address. The topmost program window is wired to the last bank and cannot be changed. The bank counts are parameters and must be powers of two. Stored bank numbers are cut to the width those counts need, both on the outputs and in the translated addresses.

Top module: `nibble_bank_decoder`

## Requirements
- R1: Only bits 3:0 of `wr_data` are stored. A write to the even address of a pair replaces register bits 3:0, and a write to the odd address replaces bits 7:4. The other half keeps its value, whichever half is written first.
- R2: The program bank registers sit at these pairs: 0x8000/0x8001 drives window 0 (CPU 0x8000–0x9FFF), 0x8002/0x8003 drives window 1 (0xA000–0xBFFF), and 0x9000/0x9001 drives window 2 (0xC000–0xDFFF). `prg_addr` = {bank, `cpu_addr[12:0]`}, and the window is chosen by `cpu_addr[14:13]`.
- R3: Window 3 (CPU 0xE000–0xFFFF, `cpu_addr[14:13]`=3) always uses bank PRG_BANKS-1.
- R4: Character windows 0 to 7 use the registers at 0xA000/1, 0xA002/3, 0xB000/1, 0xB002/3, 0xC000/1, 0xC002/3, 0xD000/1 and 0xD002/3, in that order. `chr_addr` = {bank, `ppu_addr[9:0]`}, and the window is chosen by `ppu_addr[12:10]`.
- R5: A write to 0xF002 sets `mirror` from `wr_data[1:0]`. Value 0 gives 2'b00 (horizontal), value 1 gives 2'b01 (vertical), and value 2 or 3 gives 2'b10 (four-screen).
- R6: While `rst_n` is low, every bank register and `mirror` clear to 0. The exception is the window 2 program register, which takes PRG_BANKS-2.
- R7: Bank numbers on `prg_bank`, `chr_bank` and in the translated addresses keep only their low log2(count) bits. `prg_bank` packs window w at bits [w*PRG_BW +: PRG_BW], and `chr_bank` packs its windows the same way.
- R8: Some writes change nothing: any address outside the map (including 0x9002/0x9003, 0x8004, 0xA004, 0xD00B, 0xE000–0xF001, 0xF003 and 0x0000), and any cycle with `wr_en` low.
- R9: A write is taken at the rising clock edge. Translated addresses still use the old value before that edge and the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data (bits 3:0 used) |
| cpu_addr | input | 15 | Offset within the 32 KB program area |
| ppu_addr | input | 13 | Video pattern-space address |
| prg_addr | output | PRG_BW+13 | Banked program ROM address |
| chr_addr | output | CHR_BW+10 | Banked character ROM address |
| prg_bank | output | 3*PRG_BW | Program bank numbers, windows 0–2 |
| chr_bank | output | 8*CHR_BW | Character bank numbers, windows 0–7 |
| mirror | output | 2 | Mirroring mode |

## Verification
The hard case is a register holding a value that only one half-write can produce. Reaching it takes the two nibbles in each order, with some earlier contents that the second write must not disturb. The stimulus table loads some pairs low-half first and others high-half first. It then probes the window through the translated address, so both halves show together. The program window 0 register is given a high nibble whose bit 5 falls beyond the bank mask. Writes that nearly match a register address are aimed at registers already holding known values, so a stray write would show as a changed address.

// File: rtl/nibble_bank_decoder.sv
module nibble_bank_decoder #(
  parameter int PRG_BANKS = 32,
  parameter int CHR_BANKS = 256,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int CHR_BW = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRG_BW + 13,
  localparam int CHR_AW = CHR_BW + 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [15:0]           wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [14:0]           cpu_addr,
  input  logic [12:0]           ppu_addr,
  output logic [PRG_AW-1:0]     prg_addr,
  output logic [CHR_AW-1:0]     chr_addr,
  output logic [3*PRG_BW-1:0]   prg_bank,
  output logic [8*CHR_BW-1:0]   chr_bank,
  output logic [1:0]            mirror
);
  localparam int NPRG = 3;
  localparam int NCHR = 8;
  localparam int NREG = NPRG + NCHR;
  localparam logic [7:0] PRG_LAST = 8'(PRG_BANKS - 1);
  localparam logic [7:0] PRG_PEN  = 8'(PRG_BANKS - 2);

  logic [7:0] bank_q [NREG];
  logic [1:0] mirror_q;
  logic [3:0] sel_idx;
  logic [3:0] chr_grp;
  logic       sel_hit;
  logic       mir_hit;
  logic [PRG_BW-1:0] prg_sel;

  assign chr_grp = wr_addr[15:12] - 4'hA;
  assign mir_hit = wr_en && (wr_addr == 16'hF002);

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = 4'd0;
    if (wr_addr[11:2] == 10'd0) begin
      case (wr_addr[15:12])
        4'h8: begin
          sel_hit = 1'b1;
          sel_idx = {3'd0, wr_addr[1]};
        end
        4'h9: begin
          sel_hit = !wr_addr[1];
          sel_idx = 4'd2;
        end
        4'hA, 4'hB, 4'hC, 4'hD: begin
          sel_hit = 1'b1;
          sel_idx = 4'd3 + {1'b0, chr_grp[1:0], wr_addr[1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        bank_q[i] <= (i == 2) ? PRG_PEN : 8'h00;
      mirror_q <= 2'b00;
    end else begin
      if (wr_en && sel_hit) begin
        if (wr_addr[0]) bank_q[sel_idx][7:4] <= wr_data[3:0];
        else            bank_q[sel_idx][3:0] <= wr_data[3:0];
      end
      if (mir_hit)
        mirror_q <= wr_data[1] ? 2'b10 : {1'b0, wr_data[0]};
    end
  end

  for (genvar g = 0; g < NPRG; g++) begin : g_prg
    assign prg_bank[g*PRG_BW +: PRG_BW] = bank_q[g][PRG_BW-1:0];
  end

  for (genvar g = 0; g < NCHR; g++) begin : g_chr
    assign chr_bank[g*CHR_BW +: CHR_BW] = bank_q[g+NPRG][CHR_BW-1:0];
  end

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    prg_sel = prg_bank[0*PRG_BW +: PRG_BW];
      2'd1:    prg_sel = prg_bank[1*PRG_BW +: PRG_BW];
      2'd2:    prg_sel = prg_bank[2*PRG_BW +: PRG_BW];
      default: prg_sel = PRG_LAST[PRG_BW-1:0];
    endcase
  end

  assign prg_addr = {prg_sel, cpu_addr[12:0]};
  assign chr_addr = {chr_bank[ppu_addr[12:10]*CHR_BW +: CHR_BW], ppu_addr[9:0]};
  assign mirror   = mirror_q;
endmodule

// File: rtl/nibble_bank_decoder_sva.sv
module nibble_bank_decoder_sva #(
  parameter int PRG_BANKS = 32,
  parameter int CHR_BANKS = 256,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int CHR_BW = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRG_BW + 13,
  localparam int CHR_AW = CHR_BW + 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [15:0]         wr_addr,
  input logic [7:0]          wr_data,
  input logic [14:0]         cpu_addr,
  input logic [12:0]         ppu_addr,
  input logic [PRG_AW-1:0]   prg_addr,
  input logic [CHR_AW-1:0]   chr_addr,
  input logic [3*PRG_BW-1:0] prg_bank,
  input logic [8*CHR_BW-1:0] chr_bank,
  input logic [1:0]          mirror
);
  a_r1_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 16'hA000 |=> chr_bank[3:0] == $past(wr_data[3:0]));

  a_r1_keep_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 16'hA000 |=> chr_bank[CHR_BW-1:4] == $past(chr_bank[CHR_BW-1:4]));

  a_r3_last_window: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14:13] == 2'd3 |-> prg_addr[PRG_AW-1:13] == {PRG_BW{1'b1}});

  a_r2_window0: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14:13] == 2'd0 |-> prg_addr == {prg_bank[PRG_BW-1:0], cpu_addr[12:0]});

  a_r5_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 16'hF002 |=>
      mirror == ($past(wr_data[1]) ? 2'b10 : {1'b0, $past(wr_data[0])}));

  a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr[15:12] == 4'hE |=>
      $stable(prg_bank) && $stable(chr_bank) && $stable(mirror));

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prg_bank) && $stable(chr_bank) && $stable(mirror));

  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr[9:0] == ppu_addr[9:0]);
endmodule

bind nibble_bank_decoder nibble_bank_decoder_sva #(
  .PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
  .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror)
);

// File: tb/nibble_bank_decoder_bench.sv
`timescale 1ns/100ps
module nibble_bank_decoder_bench;
  localparam int PRG_BANKS = 32;
  localparam int CHR_BANKS = 256;
  localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
  localparam int CHR_AW = $clog2(CHR_BANKS) + 10;
  localparam int PRG_BW = $clog2(PRG_BANKS);
  localparam int CHR_BW = $clog2(CHR_BANKS);
  localparam int NVEC = 35;
  localparam logic [12:0] POFF = 13'h0ABC;
  localparam logic [9:0]  COFF = 10'h155;

  // {address, data, probe select (0-2 prg window, 3-10 chr window 0-7, 11 mirror), expected}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h8000, 8'hA5, 8'd0,  8'h05},  // R1 R2 low half, upper data bits dropped
    {16'h8001, 8'h03, 8'd0,  8'h35},  // R1 R7 masked to 0x15
    {16'h8003, 8'h01, 8'd1,  8'h10},  // R1 high half first
    {16'h8002, 8'h07, 8'd1,  8'h17},
    {16'h9000, 8'h04, 8'd2,  8'h14},  // R2 keeps reset high half
    {16'h9001, 8'h00, 8'd2,  8'h04},
    {16'hA000, 8'h02, 8'd3,  8'h02},  // R4
    {16'hA001, 8'h09, 8'd3,  8'h92},
    {16'hA003, 8'h0C, 8'd4,  8'hC0},
    {16'hA002, 8'h01, 8'd4,  8'hC1},
    {16'hB000, 8'h03, 8'd5,  8'h03},
    {16'hB001, 8'h07, 8'd5,  8'h73},
    {16'hB002, 8'h0E, 8'd6,  8'h0E},
    {16'hB003, 8'h05, 8'd6,  8'h5E},
    {16'hC000, 8'h08, 8'd7,  8'h08},
    {16'hC001, 8'h0F, 8'd7,  8'hF8},
    {16'hC002, 8'h06, 8'd8,  8'h06},
    {16'hC003, 8'h0A, 8'd8,  8'hA6},
    {16'hD000, 8'h0B, 8'd9,  8'h0B},
    {16'hD001, 8'h0D, 8'd9,  8'hDB},
    {16'hD003, 8'h04, 8'd10, 8'h40},
    {16'hD002, 8'h09, 8'd10, 8'h49},
    {16'hF002, 8'h01, 8'd11, 8'h01},  // R5 vertical
    {16'hF002, 8'h02, 8'd11, 8'h02},  // R5 four-screen
    {16'hF002, 8'h07, 8'd11, 8'h02},  // R5 value 3
    {16'hF002, 8'hF4, 8'd11, 8'h00},  // R5 horizontal
    {16'h9002, 8'h0F, 8'd2,  8'h04},  // R8
    {16'h8004, 8'h0F, 8'd0,  8'h35},  // R8
    {16'hE000, 8'h0F, 8'd11, 8'h00},  // R8
    {16'hA004, 8'h0F, 8'd3,  8'h92},  // R8
    {16'hF003, 8'h03, 8'd11, 8'h00},  // R8
    {16'h0000, 8'h0F, 8'd0,  8'h35},  // R8
    {16'hF001, 8'h0F, 8'd3,  8'h92},  // R8
    {16'hD00B, 8'h0F, 8'd9,  8'hDB},  // R8
    {16'hA000, 8'hF7, 8'd3,  8'h97}   // R1 upper data bits dropped
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] cpu_addr = '0;
  logic [12:0] ppu_addr = '0;
  logic [PRG_AW-1:0] prg_addr;
  logic [CHR_AW-1:0] chr_addr;
  logic [3*PRG_BW-1:0] prg_bank;
  logic [8*CHR_BW-1:0] chr_bank;
  logic [1:0] mirror;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nibble_bank_decoder #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_nibble_bank_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror(mirror)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Probe one window (or mirror) through the ports; expected from the bank number given.
  task automatic probe(input int sel, input logic [7:0] bank, input string tag);
    logic [31:0] exp;
    if (sel < 4 && sel != 3 || sel == 3 && 0) ;
    if (sel <= 2 || sel == 12) begin
      cpu_addr = 15'((sel == 12 ? 3 : sel) * 8192) | 15'(POFF);
      exp = ((32'(bank) & 32'(PRG_BANKS - 1)) << 13) | 32'(POFF);
      #1 chk(tag, 32'(prg_addr), exp);
    end else if (sel <= 10) begin
      ppu_addr = 13'((sel - 3) * 1024) | 13'(COFF);
      exp = ((32'(bank) & 32'(CHR_BANKS - 1)) << 10) | 32'(COFF);
      #1 chk(tag, 32'(chr_addr), exp);
    end else begin
      #1 chk(tag, 32'(mirror), 32'(bank));
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    probe(0, 8'h00, "R6 prg window0 reset");
    probe(1, 8'h00, "R6 prg window1 reset");
    probe(2, 8'(PRG_BANKS - 2), "R6 prg window2 reset");
    for (int w = 3; w <= 10; w++) probe(w, 8'h00, "R6 chr reset");
    probe(11, 8'h00, "R6 mirror reset");
    rst_n = 1'b1;
    @(negedge clk);
    probe(12, 8'(PRG_BANKS - 1), "R3 last window after reset");

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][39:24], VEC[i][23:16]);
      probe(int'(VEC[i][15:8]), VEC[i][7:0], $sformatf("R1/R2/R4/R5/R7/R8 vector %0d", i));
    end

    // R7 packed bank outputs
    #1 chk("R7 prg_bank window0 masked", 32'(prg_bank[0 +: PRG_BW]), 32'h15);
    chk("R7 chr_bank window7", 32'(chr_bank[7*CHR_BW +: CHR_BW]), 32'h49);

    // R3 fixed window unaffected by writes
    probe(12, 8'(PRG_BANKS - 1), "R3 last window after writes");

    // R8 strobe low
    @(negedge clk);
    wr_addr = 16'h8000; wr_data = 8'h0F; wr_en = 1'b0;
    @(negedge clk);
    probe(0, 8'h35, "R8 strobe low ignored");

    // R9 change visible only after the edge
    @(negedge clk);
    ppu_addr = 13'(COFF);
    wr_addr = 16'hA000; wr_data = 8'h05; wr_en = 1'b1;
    #1 chk("R9 old value before edge", 32'(chr_addr), (32'h97 << 10) | 32'(COFF));
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R9 new value after edge", 32'(chr_addr), (32'h95 << 10) | 32'(COFF));

    // R6 reset mid-run
    wr(16'hF002, 8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    probe(2, 8'(PRG_BANKS - 2), "R6 prg window2 after reset");
    probe(10, 8'h00, "R6 chr window7 after reset");
    probe(11, 8'h00, "R6 mirror after reset");
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule